// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 16-bit logical address into a 20-bit physical address for a processor core. The top nibble of the logical address picks a region: a fixed top window, a stack region, a data region or an untranslated base region. The stack and data regions begin at two programmable boundary nibbles that share one 8-bit boundary register. Each translated region adds its own 8-bit bank value, shifted left by 12, to the logical address, and the sum wraps at 20 bits.

Translation is combinational from the current register contents. The registers are loaded through a small write port. A separate strobe loads the top-window page, as a far jump or far call does. A 16-bit access also needs the address of its second byte, so the block presents that address as well. For I/O cycles the block does not translate and passes the I/O address through. For internal I/O it can cut that address down to its low 8 bits.

Top module: `mmu_xlate`

## Requirements
- R1: In a memory cycle (`io_mode_i` = 2'b00), a logical nibble (bits 15:12) of 0xE or above selects the top window: `phys_o` = logical + (page register << 12) and `region_o` = 3.
- R2: In a memory cycle, a nibble below 0xE and at or above the upper boundary nibble (bits 7:4 of the boundary register) selects the stack region: the stack bank << 12 is added and `region_o` = 2.
- R3: In a memory cycle, a nibble below both 0xE and the upper boundary, and at or above the lower boundary nibble (bits 3:0), selects the data region: the data bank << 12 is added and `region_o` = 1.
- R4: In a memory cycle, a nibble below both boundaries is not translated: `phys_o` = logical zero-extended and `region_o` = 0.
- R5: The addition wraps modulo 2^20.
- R6: `phys_hi_o` is the address of the upper byte of a little-endian word: (`phys_o` + 1) mod 2^20.
- R7: A write with `cfg_we_i` updates a register at the next rising clock edge. The select codes are 0 boundary, 1 data bank, 2 stack bank, 3 page, 4 I/O control. Codes 5 to 7 are ignored. Before that edge the translation uses the old value. Reset clears all registers.
- R8: `page_ld_i` loads `page_val_i` into the page register at the next edge. It takes priority over a write to code 3 in the same cycle.
- R9: In an internal I/O cycle (`io_mode_i` = 2'b01), `phys_o` is the zero-extended low 8 address bits when bit 7 of the I/O control register is 0. It is the zero-extended 16-bit address when that bit is 1. `region_o` = 0.
- R10: In an external I/O cycle (`io_mode_i[1]` = 1), `phys_o` is the zero-extended logical address and `region_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 3 | Register select code |
| cfg_wdata_i | input | 8 | Register write data |
| page_ld_i | input | 1 | Page load strobe for far transfers |
| page_val_i | input | 8 | Page value from the instruction operand |
| io_mode_i | input | 2 | 00 memory, 01 internal I/O, 1x external I/O |
| laddr_i | input | 16 | Logical address |
| phys_o | output | 20 | Physical address of the low byte |
| phys_hi_o | output | 20 | Physical address of the high byte |
| region_o | output | 2 | Selected region: 0 none, 1 data, 2 stack, 3 top window |

## Verification
A corrupted bank or boundary register has no visible effect until an address falls in the region it governs. After that, the physical address or the region code is wrong in the same cycle, with no extra latency. The bench therefore probes the addresses on either side of each boundary nibble after every register change. A write that lands a cycle late or early shows up when the output is sampled before and after the capturing edge. A wrong result in the wrap or the byte increment shows only at the top of the 20-bit space, so those addresses are probed directly.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;
  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_DATA  = 2'd1,
    RGN_STACK = 2'd2,
    RGN_TOP   = 2'd3
  } region_e;

  localparam int unsigned SEL_W     = 3;
  localparam int unsigned NUM_REGS  = 5;
  localparam int unsigned SEL_BOUND = 0;
  localparam int unsigned SEL_DATA  = 1;
  localparam int unsigned SEL_STACK = 2;
  localparam int unsigned SEL_PAGE  = 3;
  localparam int unsigned SEL_IOCTL = 4;
endpackage

// File: rtl/mmu_bank_regs.sv
module mmu_bank_regs
  import mmu_xlate_pkg::*;
#(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic              ld_i,
  input  logic [BANK_W-1:0] ld_val_i,
  output logic [BANK_W-1:0] bound_o,
  output logic [BANK_W-1:0] data_o,
  output logic [BANK_W-1:0] stack_o,
  output logic [BANK_W-1:0] page_o,
  output logic [BANK_W-1:0] ioctl_o
);
  logic [BANK_W-1:0] q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == SEL_PAGE) begin : g_page
      // far-transfer load wins over a register write
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               q[i] <= '0;
        else if (ld_i)                             q[i] <= ld_val_i;
        else if (we_i && sel_i == SEL_W'(i))       q[i] <= wdata_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               q[i] <= '0;
        else if (we_i && sel_i == SEL_W'(i))       q[i] <= wdata_i;
      end
    end
  end

  assign bound_o = q[SEL_BOUND];
  assign data_o  = q[SEL_DATA];
  assign stack_o = q[SEL_STACK];
  assign page_o  = q[SEL_PAGE];
  assign ioctl_o = q[SEL_IOCTL];
endmodule

// File: rtl/mmu_region_dec.sv
module mmu_region_dec
  import mmu_xlate_pkg::*;
#(
  parameter int unsigned NIB_W   = 4,
  parameter logic [3:0]  TOP_NIB = 4'hE
) (
  input  logic [NIB_W-1:0] nib_i,
  input  logic [NIB_W-1:0] upper_i,
  input  logic [NIB_W-1:0] lower_i,
  output region_e          region_o
);
  always_comb begin
    if (nib_i >= NIB_W'(TOP_NIB))  region_o = RGN_TOP;
    else if (nib_i >= upper_i)     region_o = RGN_STACK;
    else if (nib_i >= lower_i)     region_o = RGN_DATA;
    else                           region_o = RGN_NONE;
  end
endmodule

// File: rtl/mmu_phys_add.sv
module mmu_phys_add #(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned PADDR_W = 20,
  parameter int unsigned BANK_W  = 8,
  parameter int unsigned SHIFT   = 12
) (
  input  logic [LADDR_W-1:0] laddr_i,
  input  logic [BANK_W-1:0]  bank_i,
  output logic [PADDR_W-1:0] phys_o
);
  localparam int unsigned OFF_W = BANK_W + SHIFT;
  logic [OFF_W-1:0] offset;

  assign offset = {bank_i, {SHIFT{1'b0}}};
  assign phys_o = PADDR_W'(laddr_i) + PADDR_W'(offset);
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_xlate_pkg::*;
#(
  parameter int unsigned LADDR_W  = 16,
  parameter int unsigned PADDR_W  = 20,
  parameter int unsigned BANK_W   = 8,
  parameter int unsigned SHIFT    = 12,
  parameter logic [3:0]  TOP_NIB  = 4'hE,
  parameter int unsigned IOWIDE_B = 7,
  parameter int unsigned IO_NARROW_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [BANK_W-1:0]  cfg_wdata_i,
  input  logic               page_ld_i,
  input  logic [BANK_W-1:0]  page_val_i,
  input  logic [1:0]         io_mode_i,
  input  logic [LADDR_W-1:0] laddr_i,
  output logic [PADDR_W-1:0] phys_o,
  output logic [PADDR_W-1:0] phys_hi_o,
  output logic [1:0]         region_o
);
  localparam int unsigned NIB_W = LADDR_W - SHIFT;

  logic [BANK_W-1:0]  bound_q, data_q, stack_q, page_q, ioctl_q;
  logic [BANK_W-1:0]  bank_sel;
  logic [PADDR_W-1:0] mem_phys;
  logic [LADDR_W-1:0] io_addr;
  region_e            rgn;
  logic               mem_cyc;

  mmu_bank_regs #(.BANK_W(BANK_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .ld_i     (page_ld_i),
    .ld_val_i (page_val_i),
    .bound_o  (bound_q),
    .data_o   (data_q),
    .stack_o  (stack_q),
    .page_o   (page_q),
    .ioctl_o  (ioctl_q)
  );

  mmu_region_dec #(.NIB_W(NIB_W), .TOP_NIB(TOP_NIB)) u_dec (
    .nib_i    (laddr_i[LADDR_W-1 -: NIB_W]),
    .upper_i  (bound_q[2*NIB_W-1 -: NIB_W]),
    .lower_i  (bound_q[NIB_W-1:0]),
    .region_o (rgn)
  );

  always_comb begin
    unique case (rgn)
      RGN_TOP:   bank_sel = page_q;
      RGN_STACK: bank_sel = stack_q;
      RGN_DATA:  bank_sel = data_q;
      default:   bank_sel = '0;
    endcase
  end

  mmu_phys_add #(
    .LADDR_W (LADDR_W), .PADDR_W (PADDR_W),
    .BANK_W  (BANK_W),  .SHIFT   (SHIFT)
  ) u_add (
    .laddr_i (laddr_i),
    .bank_i  (bank_sel),
    .phys_o  (mem_phys)
  );

  assign mem_cyc = (io_mode_i == 2'b00);

  // internal I/O decodes only the low byte unless the wide bit is set
  always_comb begin
    if (io_mode_i == 2'b01 && !ioctl_q[IOWIDE_B])
      io_addr = LADDR_W'(laddr_i[IO_NARROW_W-1:0]);
    else
      io_addr = laddr_i;
  end

  assign phys_o    = mem_cyc ? mem_phys : PADDR_W'(io_addr);
  assign phys_hi_o = phys_o + PADDR_W'(1);
  assign region_o  = mem_cyc ? rgn : RGN_NONE;
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk
  import mmu_xlate_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [2:0]  cfg_sel_i,
  input logic [7:0]  cfg_wdata_i,
  input logic        page_ld_i,
  input logic [7:0]  page_val_i,
  input logic [1:0]  io_mode_i,
  input logic [15:0] laddr_i,
  input logic [19:0] phys_o,
  input logic [1:0]  region_o,
  input logic [7:0]  page_q,
  input logic [7:0]  bound_q,
  input logic [7:0]  ioctl_q
);
  // R8
  page_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_ld_i |=> page_q == $past(page_val_i));

  // R7
  page_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == 3'd3 && !page_ld_i) |=> page_q == $past(cfg_wdata_i));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !page_ld_i) |=> ($stable(page_q) && $stable(bound_q) && $stable(ioctl_q)));

  // R10
  ext_io_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_mode_i[1] |-> (phys_o == {4'h0, laddr_i} && region_o == 2'd0));

  // R9
  int_io_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_mode_i == 2'b01 && !ioctl_q[7]) |-> (phys_o[19:8] == 12'h0 && region_o == 2'd0));

  // R1
  top_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_mode_i == 2'b00 && laddr_i[15:12] >= 4'hE) |-> region_o == 2'd3);
endmodule

bind mmu_xlate mmu_xlate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_sel_i   (cfg_sel_i),
  .cfg_wdata_i (cfg_wdata_i),
  .page_ld_i   (page_ld_i),
  .page_val_i  (page_val_i),
  .io_mode_i   (io_mode_i),
  .laddr_i     (laddr_i),
  .phys_o      (phys_o),
  .region_o    (region_o),
  .page_q      (page_q),
  .bound_q     (bound_q),
  .ioctl_q     (ioctl_q)
);

// File: tb/mmu_xlate_bench.sv
module mmu_xlate_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        page_ld_i = 1'b0;
  logic [7:0]  page_val_i = '0;
  logic [1:0]  io_mode_i = '0;
  logic [15:0] laddr_i = '0;
  logic [19:0] phys_o, phys_hi_o;
  logic [1:0]  region_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_bound = 0, m_data = 0, m_stack = 0, m_page = 0, m_ioctl = 0;

  mmu_xlate u_mmu_xlate (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [1:0] exp_region(logic [15:0] a, logic [1:0] md);
    if (md != 2'b00)                return 2'd0;
    if (a[15:12] >= 4'hE)           return 2'd3;
    if (a[15:12] >= m_bound[7:4])   return 2'd2;
    if (a[15:12] >= m_bound[3:0])   return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [19:0] exp_phys(logic [15:0] a, logic [1:0] md);
    logic [7:0] b;
    if (md[1]) return {4'h0, a};
    if (md == 2'b01) return m_ioctl[7] ? {4'h0, a} : {12'h0, a[7:0]};
    case (exp_region(a, md))
      2'd3: b = m_page;
      2'd2: b = m_stack;
      2'd1: b = m_data;
      default: b = 8'h0;
    endcase
    return {4'h0, a} + {b, 12'h000};
  endfunction

  task automatic probe(input logic [15:0] a, input logic [1:0] md, input string req);
    logic [19:0] ep;
    laddr_i = a; io_mode_i = md;
    #2;
    ep = exp_phys(a, md);
    n_cmp++;
    if (phys_o !== ep || phys_hi_o !== ep + 20'd1 || region_o !== exp_region(a, md)) begin
      n_bad++;
      $display("FAIL %s addr=%h mode=%0d: phys=%h hi=%h rgn=%0d expected phys=%h hi=%h rgn=%0d",
               req, a, md, phys_o, phys_hi_o, region_o, ep, ep + 20'd1, exp_region(a, md));
    end
  endtask

  task automatic model_update(input logic we, input logic [2:0] s, input logic [7:0] d,
                              input logic ld, input logic [7:0] v);
    if (we) case (s)
      3'd0: m_bound = d;
      3'd1: m_data  = d;
      3'd2: m_stack = d;
      3'd3: m_page  = d;
      3'd4: m_ioctl = d;
      default: ;
    endcase
    if (ld) m_page = v;
  endtask

  task automatic cycle(input logic we, input logic [2:0] s, input logic [7:0] d,
                       input logic ld, input logic [7:0] v);
    @(negedge clk_i);
    cfg_we_i = we; cfg_sel_i = s; cfg_wdata_i = d; page_ld_i = ld; page_val_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0; page_ld_i = 1'b0;
    model_update(we, s, d, ld, v);
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    cycle(1'b1, s, d, 1'b0, 8'h0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #45 rst_ni = 1'b1;
    // R7 reset: boundaries 0 -> stack region with zero bank
    probe(16'h1234, 2'b00, "R7 reset");
    probe(16'hE001, 2'b00, "R1 reset");

    wr(3'd0, 8'hD6); wr(3'd1, 8'h10); wr(3'd2, 8'h20); wr(3'd3, 8'h30);
    probe(16'h5FFF, 2'b00, "R4");
    probe(16'h0000, 2'b00, "R4");
    probe(16'h6000, 2'b00, "R3");
    probe(16'hCFFF, 2'b00, "R3");
    probe(16'hD000, 2'b00, "R2");
    probe(16'hDFFF, 2'b00, "R2");
    probe(16'hE000, 2'b00, "R1");
    probe(16'hFFFF, 2'b00, "R1");

    // R5 wrap and R6 byte-increment wrap
    wr(3'd3, 8'hFF);
    probe(16'hFFFF, 2'b00, "R5");
    wr(3'd3, 8'hF1);
    probe(16'hEFFF, 2'b00, "R6");

    // R7 unused codes ignored
    wr(3'd5, 8'h00); wr(3'd6, 8'hFF); wr(3'd7, 8'h00);
    probe(16'h7123, 2'b00, "R7 ignored");
    probe(16'hD456, 2'b00, "R7 ignored");
    probe(16'h2000, 2'b00, "R7 ignored");

    // R7 write timing: old value before the edge, new after
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 3'd3; cfg_wdata_i = 8'h44;
    probe(16'hE100, 2'b00, "R7 before edge");
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    model_update(1'b1, 3'd3, 8'h44, 1'b0, 8'h0);
    probe(16'hE100, 2'b00, "R7 after edge");

    // R8 load strobe, and priority over a same-cycle write
    cycle(1'b0, 3'd0, 8'h00, 1'b1, 8'h5A);
    probe(16'hF000, 2'b00, "R8 load");
    cycle(1'b1, 3'd3, 8'h11, 1'b1, 8'h77);
    probe(16'hF321, 2'b00, "R8 priority");

    // R9 and R10 I/O bypass
    probe(16'hABCD, 2'b01, "R9 narrow");
    wr(3'd4, 8'h80);
    probe(16'hABCD, 2'b01, "R9 wide");
    wr(3'd4, 8'h7F);
    probe(16'h12FE, 2'b01, "R9 narrow");
    probe(16'hABCD, 2'b10, "R10");
    probe(16'hFFFF, 2'b11, "R10");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 4)       wr(3'($urandom_range(0, 7)), 8'($urandom));
      else if (op == 4) cycle(1'($urandom), 3'($urandom_range(0, 4)), 8'($urandom), 1'b1, 8'($urandom));
      for (int k = 0; k < 3; k++) begin
        int mr = $urandom_range(0, 9);
        logic [1:0] md = (mr < 7) ? 2'b00 : (mr < 9) ? 2'b01 : 2'b10;
        probe(16'($urandom), md, "R1/R2/R3/R4/R5/R6/R9/R10 random");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule